// File: doc/BRIEF.md
# Serial-Controlled Successive-Approximation Converter Control Logic

This block is the digital side of a multichannel 8-bit successive-approximation converter that a host drives over a short serial link. The host pulls chip select low, clocks in a 4-bit channel address on the serial clock and reads back the result of the previous conversion on the same clocks. The result is one access behind: each access returns what the access before it started. A separate system clock runs all of the logic. It filters chip select, samples the serial clock and address through synchronisers, and times the conversion.

The analog parts are represented by digital stubs. The block drives a channel selector, a sample strobe, a hold strobe and a trial code for an external comparator. The comparator answers on a single bit. For the self-test channel and the spare channels, the block replaces the external comparator with built-in constant levels. During the hold phase, a binary search sets one result bit per step, MSB first. The result register is written only when the fixed 36-cycle conversion window has run to its end.

Top module: `sar_serial_ctrl`

## Requirements
- R1: After reset the output enable, sample strobe and hold strobe are low, and the stored result is 0. The first access after reset therefore reads 0x00.
- R2: A low level on cs_n is accepted only after three consecutive system-clock samples see it low. A shorter low pulse never enables the output.
- R3: While cs_n is sampled high, sdo_oe drops on the next clock. Toggling sclk and addr_in during that time changes neither the stored address nor the result.
- R4: When a select is accepted, sdo shows bit 7 of the stored result before any serial clock. Each of the next seven falling sclk edges moves the next lower bit onto sdo.
- R5: The channel address is taken MSB first from addr_in on the first four rising sclk edges of an access.
- R6: sample_en rises after the 4th falling sclk edge and ch_sel then equals the captured address. sample_en stays low before that edge.
- R7: On the 8th falling sclk edge, sample_en drops and hold_en rises. hold_en stays high for exactly 36 system clocks, and ch_sel is stable during that time.
- R8: For channels 0 to 10, the search treats cmp_in=1 as "input at or above dac_code". The result equals the input level.
- R9: Channel 11 (binary 1011) converts the internal self-test level and gives 128, which lies within 125..131. Channels 12 to 15 convert a constant level and give 0.
- R10: The result changes only at the end of a full conversion window. A select accepted while hold_en is high ends the conversion at once and keeps the older result.
- R11: If cs_n stays low through a conversion, sdo is reloaded with the new result's MSB when it completes, and a new access can follow without deselecting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock driving all logic and the conversion |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, synchronised internally |
| addr_in | input | 1 | Serial channel address, MSB first |
| cmp_in | input | 1 | Comparator answer: 1 when the selected input is at or above dac_code |
| sdo | output | 1 | Serial result bit, valid while sdo_oe is high |
| sdo_oe | output | 1 | Enable for the external three-state output driver |
| ch_sel | output | 4 | Channel selection for the analog multiplexer stub |
| sample_en | output | 1 | Sampling phase strobe |
| hold_en | output | 1 | Hold and conversion phase strobe |
| dac_code | output | 8 | Trial code presented to the comparator |

## Verification
An address shift that is off by one shows up as a wrong ch_sel as soon as sampling starts. It then shows up as a wrong byte on the next access. A fault in the select filter or the reload logic puts a wrong MSB on sdo within a few clocks of select. A fault in the search or the commit timing, or an abort that leaks through, is invisible until the following access shifts the result out. Because of this one-access lag, every conversion is checked by the access after it, and the queue of expected bytes follows that lag.

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl #(
  parameter int W              = 8,
  parameter int AW             = 4,
  parameter int CONV_CYCLES    = 36,
  parameter int EXT_CHANNELS   = 11,
  parameter int CS_FILTER      = 3,
  parameter int SAMPLE_EDGE    = 4,
  parameter int SELFTEST_LEVEL = 128,
  parameter int STUB_LEVEL     = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          addr_in,
  input  logic          cmp_in,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [AW-1:0] ch_sel,
  output logic          sample_en,
  output logic          hold_en,
  output logic [W-1:0]  dac_code
);

  localparam int STEP = (CONV_CYCLES - 1) / W;
  localparam int CW   = $clog2(CONV_CYCLES);
  localparam int BW   = $clog2(W);
  localparam int SW   = $clog2(STEP + 1);
  localparam int FW   = $clog2(W + 1);
  localparam int RW   = $clog2(AW + 1);
  localparam int LW   = $clog2(CS_FILTER + 1);

  logic [2:0]    sclk_q;
  logic [1:0]    addr_q;
  logic [LW-1:0] low_cnt;
  logic          sel;
  logic [W-1:0]  result, sar, shreg;
  logic [AW-1:0] addr_sh;
  logic [FW-1:0] fe_cnt;
  logic [RW-1:0] re_cnt;
  logic [CW-1:0] conv_cnt;
  logic [SW-1:0] step_cnt;
  logic [BW-1:0] bit_idx;
  logic          searching;

  wire s_rise    = sclk_q[1] & ~sclk_q[2];
  wire s_fall    = ~sclk_q[1] & sclk_q[2];
  wire accept    = !cs_n && !sel && (low_cnt == LW'(CS_FILTER - 1));
  wire active    = sel && !hold_en;
  wire conv_done = hold_en && (conv_cnt == CW'(CONV_CYCLES - 1));
  wire [W-1:0] trial = sar | (W'(1) << bit_idx);

  assign dac_code = searching ? trial : sar;
  assign sdo      = shreg[W-1];
  assign sdo_oe   = sel;

  wire cmp_eff = (32'(ch_sel) < EXT_CHANNELS)  ? cmp_in :
                 (32'(ch_sel) == EXT_CHANNELS) ? (dac_code <= W'(SELFTEST_LEVEL)) :
                                                 (dac_code <= W'(STUB_LEVEL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      addr_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      addr_q <= {addr_q[0], addr_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      sel     <= 1'b0;
    end else if (cs_n) begin
      low_cnt <= '0;
      sel     <= 1'b0;
    end else if (!sel) begin
      if (accept) sel <= 1'b1;
      else        low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      sar       <= '0;
      shreg     <= '0;
      addr_sh   <= '0;
      ch_sel    <= '0;
      fe_cnt    <= '0;
      re_cnt    <= '0;
      conv_cnt  <= '0;
      step_cnt  <= '0;
      bit_idx   <= '0;
      searching <= 1'b0;
      sample_en <= 1'b0;
      hold_en   <= 1'b0;
    end else if (accept) begin
      shreg     <= result;
      fe_cnt    <= '0;
      re_cnt    <= '0;
      sample_en <= 1'b0;
      hold_en   <= 1'b0;
      searching <= 1'b0;
    end else begin
      if (cs_n) begin
        fe_cnt    <= '0;
        re_cnt    <= '0;
        sample_en <= 1'b0;
      end else if (active) begin
        if (s_rise && re_cnt < RW'(AW)) begin
          addr_sh <= {addr_sh[AW-2:0], addr_q[1]};
          re_cnt  <= re_cnt + 1'b1;
        end
        if (s_fall && fe_cnt < FW'(W)) begin
          fe_cnt <= fe_cnt + 1'b1;
          if (fe_cnt < FW'(W - 1)) shreg <= shreg << 1;
          if (fe_cnt == FW'(SAMPLE_EDGE - 1)) begin
            sample_en <= 1'b1;
            ch_sel    <= addr_sh;
          end
          if (fe_cnt == FW'(W - 1)) begin
            sample_en <= 1'b0;
            hold_en   <= 1'b1;
            conv_cnt  <= '0;
            step_cnt  <= '0;
            bit_idx   <= BW'(W - 1);
            sar       <= '0;
            searching <= 1'b1;
          end
        end
      end
      if (hold_en) begin
        conv_cnt <= conv_cnt + 1'b1;
        if (searching) begin
          if (step_cnt == SW'(STEP - 1)) begin
            step_cnt     <= '0;
            sar[bit_idx] <= cmp_eff;
            if (bit_idx == '0) searching <= 1'b0;
            else               bit_idx   <= bit_idx - 1'b1;
          end else begin
            step_cnt <= step_cnt + 1'b1;
          end
        end
        if (conv_done) begin
          hold_en <= 1'b0;
          result  <= sar;
          if (sel && !cs_n) begin
            shreg  <= sar;
            fe_cnt <= '0;
            re_cnt <= '0;
          end
        end
      end
    end
  end

  assert_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);

  // three-sample filter at the default CS_FILTER
  assert_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (!$past(cs_n, 1) && !$past(cs_n, 2) && !$past(cs_n, 3)));

  assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (sdo == $past(result[W-1])));

  assert_phases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_en, hold_en}));

  assert_sample_before_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_en) |-> $past(sample_en));

  assert_channel_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en && $past(hold_en)) |-> $stable(ch_sel));

  assert_commit_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> ($past(hold_en) && !hold_en && $past(conv_cnt) == CW'(CONV_CYCLES - 1)));

endmodule

// File: tb/sar_serial_ctrl_tb.sv
module sar_serial_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       addr_in = 1'b0;
  logic       cmp_in;
  logic       sdo, sdo_oe, sample_en, hold_en;
  logic [3:0] ch_sel;
  logic [7:0] dac_code;

  int checks = 0;
  int errors = 0;
  int hrun = 0;
  int last_len = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rd_byte;
  event got_byte;

  always #4 clk = ~clk;

  function automatic logic [7:0] lvl(input logic [3:0] ch);
    return 8'((32'(ch) * 37 + 11) % 256);
  endfunction

  assign cmp_in = (ch_sel < 4'd11) && (lvl(ch_sel) >= dac_code);

  sar_serial_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .addr_in(addr_in),
    .cmp_in(cmp_in), .sdo(sdo), .sdo_oe(sdo_oe), .ch_sel(ch_sel),
    .sample_en(sample_en), .hold_en(hold_en), .dac_code(dac_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (hold_en) hrun = hrun + 1;
    else begin
      if (hrun != 0) last_len = hrun;
      hrun = 0;
    end
  end

  initial forever begin
    logic [7:0] e;
    @(got_byte);
    e = exp_q.pop_front();
    chk(rd_byte === e, "R4/R8 read byte", rd_byte, e);
  end

  task automatic xfer(input logic [3:0] a, input logic [7:0] exp, input bit fresh);
    logic [7:0] b;
    exp_q.push_back(exp);
    if (fresh) begin
      @(negedge clk) cs_n = 1'b0;
      repeat (6) @(negedge clk);
    end
    chk(sdo_oe === 1'b1, "R4 output enabled on select", sdo_oe, 1);
    b[7] = sdo;
    for (int i = 0; i < 8; i++) begin
      if (i < 4) addr_in = a[3-i];
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      repeat (6) @(negedge clk);
      if (i < 7) b[6-i] = sdo;
      if (i == 2) chk(sample_en === 1'b0, "R6 no sampling before 4th edge", sample_en, 0);
      if (i == 3) begin
        chk(sample_en === 1'b1, "R6 sampling after 4th edge", sample_en, 1);
        chk(ch_sel === a, "R5 captured address", ch_sel, a);
      end
      if (i == 7) begin
        chk(hold_en === 1'b1 && sample_en === 1'b0, "R7 hold after 8th edge", hold_en, 1);
      end
    end
    rd_byte = b;
    -> got_byte;
  endtask

  task automatic release_wait();
    @(negedge clk) cs_n = 1'b1;
    repeat (45) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sdo_oe === 1'b0, "R1 reset output enable", sdo_oe, 0);
    chk(sample_en === 1'b0 && hold_en === 1'b0, "R1 reset strobes", {sample_en, hold_en}, 0);

    // R2: two-sample glitch on cs_n
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(sdo_oe === 1'b0, "R2 glitch rejected", sdo_oe, 0);
    end

    xfer(4'd3, 8'd0, 1);             // R1 first read is reset value
    release_wait();
    chk(last_len == 36, "R7 hold length", last_len, 36);

    xfer(4'd11, lvl(4'd3), 1);       // R8 external channel
    release_wait();
    xfer(4'd12, 8'd128, 1);          // R9 self-test
    release_wait();
    xfer(4'd5, 8'd0, 1);             // R9 spare channel
    release_wait();

    // R3: activity while deselected
    for (int k = 0; k < 10; k++) begin
      addr_in = k[0];
      repeat (4) @(negedge clk);
      sclk = ~sclk;
      repeat (4) @(negedge clk);
      chk(sdo_oe === 1'b0 && sample_en === 1'b0, "R3 ignored while deselected", sdo_oe, 0);
    end
    sclk = 1'b0;
    repeat (8) @(negedge clk);

    xfer(4'd7, lvl(4'd5), 1);        // R3 result unaffected
    // R10: abort by reselect during conversion
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(hold_en === 1'b0, "R10 conversion aborted", hold_en, 0);
    xfer(4'd9, lvl(4'd5), 0);        // R10 older result kept
    release_wait();

    // R11: stay selected through conversion
    xfer(4'd2, lvl(4'd9), 1);
    repeat (45) @(negedge clk);
    xfer(4'd10, lvl(4'd2), 0);       // R11 reloaded result
    release_wait();
    xfer(4'd0, lvl(4'd10), 1);
    release_wait();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule